// File: doc/BRIEF.md
# Linear Address Generation Unit

This unit turns the addressing fields of a memory operand into a 32-bit linear address. It can add a base register, an index register multiplied by a small power of two, and a displacement, giving an offset within a segment. It then adds the base of the chosen segment to that offset. All sums wrap modulo 2^32. The segment is chosen from the kind of access and the base register used. A segment override can replace that choice for ordinary data references.

The caller presents the eight general register values, the packed segment bases and the operand fields together with a one-cycle request strobe. One clock later the unit shows the chosen segment number, the offset and the linear address, with a valid pulse. The registered outputs keep their values until the next strobe. Segment limit and protection checks are done elsewhere.

Register codes are 0..7, in the order accumulator, count, data, base, stack pointer (4), frame pointer (5), source index, destination index. Segment codes are 0 code, 1 stack, 2 data, 3 extra, 4 auxiliary data A and 5 auxiliary data B. Segment base k sits at bits [32k+31:32k] of the packed bus, and register n sits at bits [32n+31:32n] of its own packed bus.

Top module: `agu_linear_addr`

## Requirements
- R1: `out_linear` equals the base of the segment numbered `out_seg` plus `out_offset`, and `out_offset` equals base term + index term + displacement term, both modulo 2^32.
- R2: `scale_code` values 0, 1, 2 and 3 multiply the index register value by 1, 2, 4 and 8 respectively.
- R3: `disp_size` 00 adds no displacement. 01 adds `disp[7:0]` sign-extended to 32 bits. 10 and 11 add all 32 bits of `disp`.
- R4: With `base_valid`=0 the base term is zero. With `index_valid`=0, or with `index_sel`=4 (stack pointer), the index term is zero.
- R5: `access_kind`=01 (instruction fetch) always selects segment 0 (code), whatever the override inputs are.
- R6: For a data access with no usable override, the segment is 1 (stack) when `base_valid`=1 and `base_sel` is 4 or 5, and 2 (data) otherwise.
- R7: `access_kind`=10 (string destination) always selects segment 3 (extra), whatever the override inputs are.
- R8: For data accesses (`access_kind` 00 or 11), `ovr_valid`=1 with `ovr_seg` in 0..5 selects that segment. `ovr_seg` values 6 and 7 are ignored, and the default of R6 applies.
- R9: `out_valid` is high in exactly the cycle after each cycle in which `req_valid` is high, and the outputs in that cycle reflect the inputs sampled with the strobe.
- R10: While reset is held, `out_valid`, `out_seg`, `out_offset` and `out_linear` are zero. After a cycle without a strobe, `out_seg`, `out_offset` and `out_linear` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe; inputs are sampled on this cycle |
| gpr_flat | input | 256 | Eight packed 32-bit general register values |
| base_valid | input | 1 | A base register is used |
| base_sel | input | 3 | Base register code |
| index_valid | input | 1 | An index register is used |
| index_sel | input | 3 | Index register code; 4 means no index |
| scale_code | input | 2 | Index multiplier code (1, 2, 4, 8) |
| disp | input | 32 | Displacement value |
| disp_size | input | 2 | Displacement size: none, 8-bit, 32-bit |
| access_kind | input | 2 | 00 data, 01 fetch, 10 string destination, 11 data |
| ovr_valid | input | 1 | A segment override is present |
| ovr_seg | input | 3 | Override segment code |
| seg_bases_flat | input | 192 | Six packed 32-bit segment base values |
| out_valid | output | 1 | Result valid pulse |
| out_seg | output | 3 | Chosen segment code |
| out_offset | output | 32 | Offset within the segment |
| out_linear | output | 32 | Linear address |

## Verification
The arithmetic is swept over every combination of base register and its valid bit, index register and its valid bit, scale code and displacement size. Register values differ in every byte, and the displacement flips the sign of its low byte between requests. This pattern separates a wrong scale shift, a missing sign extension, an unsuppressed stack-pointer index and a swapped register slot. A second sweep runs every access kind with every override code and base register, with distinct segment bases. This separates the fetch and string-destination rules, the stack default for the two stack-relative bases, and the rejection of out-of-range override codes. Checks between strobes confirm that the valid flag drops and the results hold.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    ACC_DATA     = 2'b00,
    ACC_FETCH    = 2'b01,
    ACC_STRDST   = 2'b10,
    ACC_DATA_ALT = 2'b11
  } acc_kind_e;

  typedef enum logic [2:0] {
    SEG_CODE  = 3'd0,
    SEG_STACK = 3'd1,
    SEG_DATA  = 3'd2,
    SEG_EXTRA = 3'd3,
    SEG_AUXA  = 3'd4,
    SEG_AUXB  = 3'd5
  } seg_id_e;

  localparam int SEG_ID_W   = 3;
  localparam int SEG_COUNT  = 6;
  localparam int REG_SP_ID  = 4;
  localparam int REG_FP_ID  = 5;

  typedef enum logic [1:0] {
    DSZ_NONE = 2'b00,
    DSZ_BYTE = 2'b01,
    DSZ_WORD = 2'b10,
    DSZ_WALT = 2'b11
  } disp_size_e;

endpackage

// File: rtl/agu_rst_sync.sv
module agu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/agu_seg_pick.sv
module agu_seg_pick
  import agu_pkg::*;
#(
  parameter int NUM_GPR = 8,
  localparam int REG_IDX_W = $clog2(NUM_GPR)
) (
  input  logic [1:0]          access_kind,
  input  logic                base_valid,
  input  logic [REG_IDX_W-1:0] base_sel,
  input  logic                ovr_valid,
  input  logic [SEG_ID_W-1:0] ovr_seg,
  output logic [SEG_ID_W-1:0] seg_sel
);

  logic stack_based;
  logic ovr_usable;
  logic [SEG_ID_W-1:0] data_default;

  always_comb begin
    stack_based = base_valid &&
                  ((base_sel == REG_IDX_W'(REG_SP_ID)) ||
                   (base_sel == REG_IDX_W'(REG_FP_ID)));
    ovr_usable  = ovr_valid && (ovr_seg < SEG_ID_W'(SEG_COUNT));
    data_default = stack_based ? SEG_STACK : SEG_DATA;
  end

  always_comb begin
    case (acc_kind_e'(access_kind))
      ACC_FETCH:  seg_sel = SEG_CODE;
      ACC_STRDST: seg_sel = SEG_EXTRA;
      default:    seg_sel = ovr_usable ? ovr_seg : data_default;
    endcase
  end

endmodule

// File: rtl/agu_operand_mux.sv
module agu_operand_mux
  import agu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_GPR = 8,
  localparam int REG_IDX_W = $clog2(NUM_GPR)
) (
  input  logic [NUM_GPR*DATA_W-1:0] gpr_flat,
  input  logic                      base_valid,
  input  logic [REG_IDX_W-1:0]      base_sel,
  input  logic                      index_valid,
  input  logic [REG_IDX_W-1:0]      index_sel,
  input  logic [1:0]                scale_code,
  input  logic [DATA_W-1:0]         disp,
  input  logic [1:0]                disp_size,
  output logic [DATA_W-1:0]         base_term,
  output logic [DATA_W-1:0]         index_term,
  output logic [DATA_W-1:0]         disp_term
);

  logic [DATA_W-1:0] gpr_val [NUM_GPR];

  for (genvar g = 0; g < NUM_GPR; g++) begin : g_unpack
    assign gpr_val[g] = gpr_flat[g*DATA_W +: DATA_W];
  end

  logic index_used;

  always_comb begin
    base_term  = base_valid ? gpr_val[base_sel] : '0;
    index_used = index_valid && (index_sel != REG_IDX_W'(REG_SP_ID));
    index_term = index_used ? (gpr_val[index_sel] << scale_code) : '0;
  end

  always_comb begin
    case (disp_size_e'(disp_size))
      DSZ_NONE: disp_term = '0;
      DSZ_BYTE: disp_term = {{(DATA_W-8){disp[7]}}, disp[7:0]};
      default:  disp_term = disp;
    endcase
  end

endmodule

// File: rtl/agu_sum.sv
module agu_sum
  import agu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_SEG = 6
) (
  input  logic [NUM_SEG*DATA_W-1:0] seg_bases_flat,
  input  logic [SEG_ID_W-1:0]       seg_sel,
  input  logic [DATA_W-1:0]         base_term,
  input  logic [DATA_W-1:0]         index_term,
  input  logic [DATA_W-1:0]         disp_term,
  output logic [DATA_W-1:0]         offset,
  output logic [DATA_W-1:0]         linear
);

  logic [DATA_W-1:0] seg_base [NUM_SEG];

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    assign seg_base[s] = seg_bases_flat[s*DATA_W +: DATA_W];
  end

  logic [DATA_W-1:0] chosen_base;

  always_comb begin
    chosen_base = '0;
    for (int k = 0; k < NUM_SEG; k++) begin
      if (seg_sel == SEG_ID_W'(k)) chosen_base = seg_base[k];
    end
    offset = base_term + index_term + disp_term;
    linear = chosen_base + offset;
  end

endmodule

// File: rtl/agu_linear_addr.sv
module agu_linear_addr
  import agu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_GPR = 8,
  parameter int NUM_SEG = 6,
  localparam int REG_IDX_W = $clog2(NUM_GPR)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [NUM_GPR*DATA_W-1:0] gpr_flat,
  input  logic                      base_valid,
  input  logic [REG_IDX_W-1:0]      base_sel,
  input  logic                      index_valid,
  input  logic [REG_IDX_W-1:0]      index_sel,
  input  logic [1:0]                scale_code,
  input  logic [DATA_W-1:0]         disp,
  input  logic [1:0]                disp_size,
  input  logic [1:0]                access_kind,
  input  logic                      ovr_valid,
  input  logic [SEG_ID_W-1:0]       ovr_seg,
  input  logic [NUM_SEG*DATA_W-1:0] seg_bases_flat,
  output logic                      out_valid,
  output logic [SEG_ID_W-1:0]       out_seg,
  output logic [DATA_W-1:0]         out_offset,
  output logic [DATA_W-1:0]         out_linear
);

  logic rst_n_int;

  agu_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  logic [SEG_ID_W-1:0] seg_sel;
  logic [DATA_W-1:0]   base_term, index_term, disp_term;
  logic [DATA_W-1:0]   offset_d, linear_d;

  agu_seg_pick #(.NUM_GPR(NUM_GPR)) u_seg_pick (
    .access_kind (access_kind),
    .base_valid  (base_valid),
    .base_sel    (base_sel),
    .ovr_valid   (ovr_valid),
    .ovr_seg     (ovr_seg),
    .seg_sel     (seg_sel)
  );

  agu_operand_mux #(.DATA_W(DATA_W), .NUM_GPR(NUM_GPR)) u_operand_mux (
    .gpr_flat    (gpr_flat),
    .base_valid  (base_valid),
    .base_sel    (base_sel),
    .index_valid (index_valid),
    .index_sel   (index_sel),
    .scale_code  (scale_code),
    .disp        (disp),
    .disp_size   (disp_size),
    .base_term   (base_term),
    .index_term  (index_term),
    .disp_term   (disp_term)
  );

  agu_sum #(.DATA_W(DATA_W), .NUM_SEG(NUM_SEG)) u_sum (
    .seg_bases_flat (seg_bases_flat),
    .seg_sel        (seg_sel),
    .base_term      (base_term),
    .index_term     (index_term),
    .disp_term      (disp_term),
    .offset         (offset_d),
    .linear         (linear_d)
  );

  // next-state
  logic                valid_d;
  logic [SEG_ID_W-1:0] seg_n;
  logic [DATA_W-1:0]   off_n, lin_n;

  always_comb begin
    valid_d = req_valid;
    seg_n   = out_seg;
    off_n   = out_offset;
    lin_n   = out_linear;
    if (req_valid) begin
      seg_n = seg_sel;
      off_n = offset_d;
      lin_n = linear_d;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      out_valid  <= 1'b0;
      out_seg    <= '0;
      out_offset <= '0;
      out_linear <= '0;
    end else begin
      out_valid  <= valid_d;
      out_seg    <= seg_n;
      out_offset <= off_n;
      out_linear <= lin_n;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n_int)
    req_valid |=> out_valid); // R9
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n_int)
    !req_valid |=> !out_valid); // R9
  AST_FETCH_CODE: assert property (@(posedge clk) disable iff (!rst_n_int)
    (req_valid && access_kind == ACC_FETCH) |=> (out_seg == SEG_CODE)); // R5
  AST_STRDST_EXTRA: assert property (@(posedge clk) disable iff (!rst_n_int)
    (req_valid && access_kind == ACC_STRDST) |=> (out_seg == SEG_EXTRA)); // R7
  AST_EMPTY_OFFSET: assert property (@(posedge clk) disable iff (!rst_n_int)
    (req_valid && !base_valid && disp_size == DSZ_NONE &&
     (!index_valid || index_sel == REG_IDX_W'(REG_SP_ID))) |=> (out_offset == '0)); // R4
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n_int)
    !req_valid |=> ($stable(out_linear) && $stable(out_offset) && $stable(out_seg))); // R10

endmodule

// File: tb/agu_linear_addr_bench.sv
module agu_linear_addr_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [255:0] gpr_flat = '0;
  logic         base_valid = 1'b0;
  logic [2:0]   base_sel = '0;
  logic         index_valid = 1'b0;
  logic [2:0]   index_sel = '0;
  logic [1:0]   scale_code = '0;
  logic [31:0]  disp = '0;
  logic [1:0]   disp_size = '0;
  logic [1:0]   access_kind = '0;
  logic         ovr_valid = 1'b0;
  logic [2:0]   ovr_seg = '0;
  logic [191:0] seg_bases_flat = '0;
  logic         out_valid;
  logic [2:0]   out_seg;
  logic [31:0]  out_offset;
  logic [31:0]  out_linear;

  int total = 0;
  int fails = 0;

  logic [31:0] gpr [8];
  logic [31:0] segb [6];

  always #2 clk = ~clk;

  agu_linear_addr u_agu_linear_addr (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .gpr_flat(gpr_flat),
    .base_valid(base_valid), .base_sel(base_sel), .index_valid(index_valid),
    .index_sel(index_sel), .scale_code(scale_code), .disp(disp),
    .disp_size(disp_size), .access_kind(access_kind), .ovr_valid(ovr_valid),
    .ovr_seg(ovr_seg), .seg_bases_flat(seg_bases_flat), .out_valid(out_valid),
    .out_seg(out_seg), .out_offset(out_offset), .out_linear(out_linear)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_seg(input logic [1:0] kind, input logic bv,
                                         input logic [2:0] bs, input logic ov,
                                         input logic [2:0] os);
    if (kind == 2'b01) return 3'd0;
    if (kind == 2'b10) return 3'd3;
    if (ov && os <= 3'd5) return os;
    if (bv && (bs == 3'd4 || bs == 3'd5)) return 3'd1;
    return 3'd2;
  endfunction

  function automatic logic [31:0] exp_off();
    logic [31:0] o = 32'd0;
    if (base_valid) o = o + gpr[base_sel];
    if (index_valid && index_sel != 3'd4) o = o + gpr[index_sel] * (32'd1 << scale_code);
    if (disp_size == 2'b01) o = o + (disp[7] ? (32'hFFFF_FF00 | disp[7:0]) : {24'd0, disp[7:0]});
    else if (disp_size[1]) o = o + disp;
    return o;
  endfunction

  task automatic load_banks(input logic [31:0] salt);
    for (int n = 0; n < 8; n++) begin
      gpr[n] = (32'h9E37_79B9 * (n + 1)) ^ salt;
      gpr_flat[n*32 +: 32] = gpr[n];
    end
    for (int s = 0; s < 6; s++) begin
      segb[s] = (32'h0100_0000 * (s + 1)) + (32'h0001_0010 * s) + salt;
      seg_bases_flat[s*32 +: 32] = segb[s];
    end
  endtask

  // drives one request at a negedge, checks results at the next negedge
  task automatic issue(input string tag);
    logic [2:0]  es;
    logic [31:0] eo;
    es = exp_seg(access_kind, base_valid, base_sel, ovr_valid, ovr_seg);
    eo = exp_off();
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R9 valid"}, {31'd0, out_valid}, 32'd1);
    check({tag, " seg"}, {29'd0, out_seg}, {29'd0, es});
    check({tag, " R1 offset"}, out_offset, eo);
    check({tag, " R1 linear"}, out_linear, segb[es] + eo);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    fails++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : main
    logic [31:0] hold_lin, hold_off;
    logic [2:0]  hold_seg;
    int iter;
    load_banks(32'h0);
    repeat (4) @(negedge clk);
    // R10 reset state
    check("R10 reset valid", {31'd0, out_valid}, 32'd0);
    check("R10 reset seg", {29'd0, out_seg}, 32'd0);
    check("R10 reset offset", out_offset, 32'd0);
    check("R10 reset linear", out_linear, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // arithmetic sweep: R1 R2 R3 R4 R6
    iter = 0;
    for (int bv = 0; bv < 2; bv++)
      for (int bs = 0; bs < 8; bs++)
        for (int iv = 0; iv < 2; iv++)
          for (int is = 0; is < 8; is++)
            for (int sc = 0; sc < 4; sc++)
              for (int ds = 0; ds < 4; ds++) begin
                if (ds == 0 && sc == 0) load_banks(32'h0005_A3C1 * iter);
                base_valid  = bv[0];
                base_sel    = bs[2:0];
                index_valid = iv[0];
                index_sel   = is[2:0];
                scale_code  = sc[1:0];
                disp_size   = ds[1:0];
                disp        = 32'h8765_43F1 ^ (32'h0101_0181 * iter);
                access_kind = 2'b00;
                ovr_valid   = 1'b0;
                issue("R2 R3 R4 R6 sweep");
                iter++;
              end

    // segment selection sweep: R5 R6 R7 R8
    base_valid = 1'b1;
    index_valid = 1'b1;
    index_sel = 3'd1;
    scale_code = 2'd3;
    disp_size = 2'b01;
    disp = 32'h0000_0080;
    for (int k = 0; k < 4; k++)
      for (int ov = 0; ov < 2; ov++)
        for (int os = 0; os < 8; os++)
          for (int bs = 0; bs < 8; bs++) begin
            access_kind = k[1:0];
            ovr_valid = ov[0];
            ovr_seg = os[2:0];
            base_sel = bs[2:0];
            issue("R5 R7 R8 kind/override");
          end

    // R9 R10 valid drops and results hold between strobes
    for (int r = 0; r < 6; r++) begin
      access_kind = 2'b00;
      ovr_valid = 1'b0;
      base_sel = r[2:0];
      disp_size = 2'b10;
      disp = 32'hF000_0000 + r;
      issue("R9 pre-hold");
      hold_lin = out_linear;
      hold_off = out_offset;
      hold_seg = out_seg;
      base_sel = 3'd7;
      disp = 32'h1234_5678;
      @(negedge clk);
      check("R9 valid low", {31'd0, out_valid}, 32'd0);
      check("R10 hold linear", out_linear, hold_lin);
      check("R10 hold offset", out_offset, hold_off);
      check("R10 hold seg", {29'd0, out_seg}, {29'd0, hold_seg});
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule